// File: doc/BRIEF.md
# Paged RAM Enable Controller

This block is a word-wide on-chip RAM divided into four equal pages, with an 8-bit control register that holds one enable bit per page. Software writes the control register through a byte-wide port; the RAM port carries a request, a write strobe, a word address and write data, and returns read data one cycle after a read request. A page whose enable bit is clear drops writes and answers reads with the filler word 0xDEADBEEF.

Each page owns a one-entry posted-write buffer, run by a two-state machine. In BUF_EMPTY, a write to the enabled page takes the *post* transition to BUF_PENDING. In BUF_PENDING, another write takes the *repost* transition: the old entry is committed to the array and the new one is held. A read of the page takes the *commit-on-read* transition back to BUF_EMPTY, writing the entry into the array. A register write that clears the page's enable bit takes the *discard* transition to BUF_EMPTY and loses the entry. A write that has not yet been followed by an access to its page is therefore lost when that page is disabled.

Two resets are provided. Power-on reset enables every page and empties every buffer. Manual reset leaves the register, the buffers and the array alone and only clears the read-data output.

Top module: `paged_ram_ctl`

## Requirements
- R1: After power-on reset the control register reads 0xFF and all four pages are enabled.
- R2: Control register bits 7..4 always read as 1, and writing them has no effect; bits 3..0 read back the enables of pages 3..0.
- R3: A register write takes effect only when reg_size is 0 (byte); sizes 1 (half), 2 (word) and 3 leave the register unchanged.
- R4: A change of enable bits takes effect at the clock edge that accepts the register write; a RAM access presented in that same cycle is handled with the old enables.
- R5: The page is selected by ram_addr[5:4]; bits 3..0 give the word within the page.
- R6: A read of an enabled page returns, one cycle after the request, the most recent data written to that address, including data still held in the posted-write buffer.
- R7: While a page is disabled, writes to it are dropped and its stored words stay unchanged, as seen after it is enabled again.
- R8: A read of a disabled page returns 0xDEADBEEF one cycle after the request.
- R9: A pending posted write is committed to the array by the next read or write to the same page, so it survives a later disable of that page.
- R10: Clearing a page's enable bit while that page has a pending posted write discards the pending data.
- R11: Manual reset keeps the control register, the posted-write buffers and the RAM contents, and clears ram_rdata to 0.
- R12: Power-on reset empties every posted-write buffer without altering the words already committed to the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, asynchronous |
| reg_wr | input | 1 | Control register write strobe |
| reg_size | input | 2 | Access size of the register write: 0 byte, 1 half, 2 word |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| ram_req | input | 1 | RAM access request |
| ram_we | input | 1 | RAM access is a write when 1, a read when 0 |
| ram_addr | input | 6 | RAM word address; top two bits select the page |
| ram_wdata | input | 32 | RAM write data |
| ram_rdata | output | 32 | RAM read data, valid the cycle after a read request |

## Verification
The assertions take for granted that at most one RAM access is presented per cycle, so at most one page can commit a buffered word to the array at a time, and that the manual reset is never asserted while the power-on reset is held in the middle of a read. They also assume address and control inputs are settled well before the clock edge. The stimulus drives every input on the falling clock edge, issues a single access per cycle, and pulses each reset on its own between accesses, so these conditions always hold; reads are only made of words written earlier, so the array never returns unknown contents.

// File: rtl/pram_pkg.sv
package pram_pkg;
    localparam int PAGE_W = 2;
    localparam int NPAGE  = 1 << PAGE_W;
    localparam int REG_W  = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        BUF_EMPTY   = 1'b0,
        BUF_PENDING = 1'b1
    } buf_state_e;
endpackage

// File: rtl/pram_enreg.sv
module pram_enreg
    import pram_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr,
    input  logic [1:0]       size,
    input  logic [REG_W-1:0] wdata,
    output logic [NPAGE-1:0] en,
    output logic [NPAGE-1:0] drop,
    output logic [REG_W-1:0] rdata
);
    logic wr_ok;
    logic unused_hi;

    assign wr_ok     = wr && (acc_size_e'(size) == SZ_BYTE);
    assign unused_hi = ^wdata[REG_W-1:NPAGE];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)     en <= '1;
        else if (wr_ok) en <= wdata[NPAGE-1:0];
    end

    // pages whose enable is cleared at this edge
    assign drop  = wr_ok ? (en & ~wdata[NPAGE-1:0]) : '0;
    assign rdata = {{(REG_W-NPAGE){1'b1}}, en};

    // non-byte accesses leave the enables untouched
    p_size_ignored_r3: assert property (@(posedge clk) disable iff (!por_n)
        (wr && size != 2'd0) |=> $stable(en));

    // a byte write is visible after exactly one edge
    p_enable_next_edge_r4: assert property (@(posedge clk) disable iff (!por_n)
        (wr && size == 2'd0) |=> (rdata[NPAGE-1:0] == $past(wdata[NPAGE-1:0])));
endmodule

// File: rtl/pram_pwbuf.sv
module pram_pwbuf
    import pram_pkg::*;
#(
    parameter int OFF_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              page_en,
    input  logic              drop,
    input  logic              acc,
    input  logic              acc_we,
    input  logic [OFF_W-1:0]  off_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              commit,
    output logic [OFF_W-1:0]  cm_off,
    output logic [DATA_W-1:0] cm_data,
    output logic              hit
);
    buf_state_e st, st_nx;
    logic [OFF_W-1:0]  off_q;
    logic [DATA_W-1:0] data_q;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st <= BUF_EMPTY;
        else        st <= st_nx;
    end

    // transitions: post, repost, commit-on-read, discard
    always_comb begin
        st_nx = st;
        unique case (st)
            BUF_EMPTY: begin
                if (drop)                st_nx = BUF_EMPTY;
                else if (acc && acc_we)  st_nx = BUF_PENDING;
            end
            BUF_PENDING: begin
                if (drop)                st_nx = BUF_EMPTY;
                else if (acc && acc_we)  st_nx = BUF_PENDING;
                else if (acc)            st_nx = BUF_EMPTY;
            end
            default:                     st_nx = BUF_EMPTY;
        endcase
    end

    // payload capture
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            off_q  <= '0;
            data_q <= '0;
        end else if (acc && acc_we) begin
            off_q  <= off_in;
            data_q <= data_in;
        end
    end

    // outputs
    always_comb begin
        commit  = (st == BUF_PENDING) && acc;
        cm_off  = off_q;
        cm_data = data_q;
        hit     = (st == BUF_PENDING) && (off_q == off_in);
    end

    // a disabled page never holds a pending word
    p_no_pending_when_off_r7: assert property (@(posedge clk) disable iff (!por_n)
        !page_en |-> (st == BUF_EMPTY));

    // disabling a page throws its pending word away
    p_discard_on_disable_r10: assert property (@(posedge clk) disable iff (!por_n)
        $fell(page_en) |-> (st == BUF_EMPTY));
endmodule

// File: rtl/pram_array.sv
module pram_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/paged_ram_ctl.sv
module paged_ram_ctl
    import pram_pkg::*;
#(
    parameter int              ADDR_W    = 6,
    parameter int              DATA_W    = 32,
    parameter logic [DATA_W-1:0] FILL_WORD = 32'hDEADBEEF
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_size,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ram_req,
    input  logic              ram_we,
    input  logic [ADDR_W-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_wdata,
    output logic [DATA_W-1:0] ram_rdata
);
    localparam int OFF_W = ADDR_W - PAGE_W;

    logic [NPAGE-1:0]  page_en, page_drop, acc, commit, hit;
    logic [OFF_W-1:0]  cm_off  [NPAGE];
    logic [DATA_W-1:0] cm_data [NPAGE];
    logic [PAGE_W-1:0] sel_page;
    logic [OFF_W-1:0]  sel_off;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [DATA_W-1:0] arr_wdata, arr_rdata;
    logic              rst_any_n;

    assign sel_page  = ram_addr[ADDR_W-1 -: PAGE_W];
    assign sel_off   = ram_addr[OFF_W-1:0];
    assign rst_any_n = por_n & mrst_n;

    pram_enreg u_enreg (
        .clk   (clk),
        .por_n (por_n),
        .wr    (reg_wr),
        .size  (reg_size),
        .wdata (reg_wdata),
        .en    (page_en),
        .drop  (page_drop),
        .rdata (reg_rdata)
    );

    for (genvar p = 0; p < NPAGE; p++) begin : g_page
        assign acc[p] = ram_req && (sel_page == PAGE_W'(p)) && page_en[p];

        pram_pwbuf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
            .clk     (clk),
            .por_n   (por_n),
            .page_en (page_en[p]),
            .drop    (page_drop[p]),
            .acc     (acc[p]),
            .acc_we  (ram_we),
            .off_in  (sel_off),
            .data_in (ram_wdata),
            .commit  (commit[p]),
            .cm_off  (cm_off[p]),
            .cm_data (cm_data[p]),
            .hit     (hit[p])
        );
    end

    // route the single committing buffer to the array write port
    always_comb begin
        arr_we    = 1'b0;
        arr_waddr = '0;
        arr_wdata = '0;
        for (int p = 0; p < NPAGE; p++) begin
            if (commit[p]) begin
                arr_we    = 1'b1;
                arr_waddr = {PAGE_W'(p), cm_off[p]};
                arr_wdata = cm_data[p];
            end
        end
    end

    pram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (ram_addr),
        .rdata (arr_rdata)
    );

    // registered read data; either reset clears it
    always_ff @(posedge clk or negedge rst_any_n) begin
        if (!rst_any_n) begin
            ram_rdata <= '0;
        end else if (ram_req && !ram_we) begin
            if (!page_en[sel_page])  ram_rdata <= FILL_WORD;
            else if (hit[sel_page])  ram_rdata <= cm_data[sel_page];
            else                     ram_rdata <= arr_rdata;
        end
    end

    // only one page may commit in a cycle
    p_single_commit_r9: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(commit));

    // reads of a disabled page answer with the filler word
    p_fill_on_disabled_r8: assert property (@(posedge clk) disable iff (!rst_any_n)
        (ram_req && !ram_we && !reg_rdata[sel_page]) |=> (ram_rdata == FILL_WORD));
endmodule

// File: tb/paged_ram_ctl_test.sv
module paged_ram_ctl_test;
    logic        clk = 1'b0;
    logic        por_n, mrst_n, reg_wr, ram_req, ram_we;
    logic [1:0]  reg_size;
    logic [7:0]  reg_wdata, reg_rdata;
    logic [5:0]  ram_addr;
    logic [31:0] ram_wdata, ram_rdata;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #5 clk = ~clk;

    paged_ram_ctl uut (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n),
        .reg_wr(reg_wr), .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // op codes: 0 ram write, 1 ram read + check, 2 register byte write, 3 register check
    localparam int NV = 21;
    localparam logic [75:0] VEC [0:NV-1] = '{
        {2'd0, 4'd6,  6'h01, 32'h11111111, 32'h0},          // R6 post page 0
        {2'd1, 4'd6,  6'h01, 32'h0,        32'h11111111},   // R6 forwarded read
        {2'd0, 4'd6,  6'h12, 32'h22222222, 32'h0},          // page 1 post
        {2'd0, 4'd9,  6'h13, 32'h33333333, 32'h0},          // R9 repost commits 0x12
        {2'd1, 4'd9,  6'h12, 32'h0,        32'h22222222},   // R9 from array
        {2'd1, 4'd6,  6'h13, 32'h0,        32'h33333333},   // R6
        {2'd0, 4'd6,  6'h25, 32'hAAAA0001, 32'h0},
        {2'd1, 4'd6,  6'h25, 32'h0,        32'hAAAA0001},   // commit-on-read
        {2'd0, 4'd10, 6'h25, 32'hAAAA0002, 32'h0},          // pending
        {2'd2, 4'd10, 6'h00, 32'h000000FB, 32'h0},          // R10 disable page 2
        {2'd3, 4'd2,  6'h00, 32'h0,        32'h000000FB},   // R2
        {2'd1, 4'd8,  6'h25, 32'h0,        32'hDEADBEEF},   // R8
        {2'd0, 4'd7,  6'h25, 32'hBBBBBBBB, 32'h0},          // R7 dropped
        {2'd2, 4'd7,  6'h00, 32'h0000000F, 32'h0},
        {2'd1, 4'd10, 6'h25, 32'h0,        32'hAAAA0001},   // R10 and R7
        {2'd0, 4'd9,  6'h3F, 32'hCCCCCCCC, 32'h0},
        {2'd0, 4'd9,  6'h30, 32'h00003030, 32'h0},          // R9 commits 0x3F
        {2'd2, 4'd9,  6'h00, 32'h00000007, 32'h0},          // discard 0x30
        {2'd2, 4'd9,  6'h00, 32'h0000000F, 32'h0},
        {2'd1, 4'd9,  6'h3F, 32'h0,        32'hCCCCCCCC},   // R9
        {2'd3, 4'd1,  6'h00, 32'h0,        32'h000000FF}    // R1 enables restored
    };

    task automatic idle();
        reg_wr = 1'b0; reg_size = 2'd0; reg_wdata = 8'h00;
        ram_req = 1'b0; ram_we = 1'b0; ram_addr = 6'h00; ram_wdata = 32'h0;
    endtask

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic reg_put(input logic [7:0] d, input logic [1:0] sz);
        reg_wr = 1'b1; reg_size = sz; reg_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic ram_put(input logic [5:0] a, input logic [31:0] d);
        ram_req = 1'b1; ram_we = 1'b1; ram_addr = a; ram_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic ram_get(input string tag, input logic [5:0] a, input logic [31:0] exp);
        ram_req = 1'b1; ram_we = 1'b0; ram_addr = a;
        @(negedge clk);
        chk32(tag, ram_rdata, exp);
        idle();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle();
        por_n = 1'b0; mrst_n = 1'b1;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk8("R1 register after power-on", reg_rdata, 8'hFF);
        chk32("R1 read data after power-on", ram_rdata, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [5:0]  ad;
            logic [31:0] dt, ex;
            {op, rq, ad, dt, ex} = VEC[i];
            unique case (op)
                2'd0: ram_put(ad, dt);
                2'd1: ram_get($sformatf("R%0d vector %0d", rq, i), ad, ex);
                2'd2: reg_put(dt[7:0], 2'd0);
                default: chk8($sformatf("R%0d vector %0d", rq, i), reg_rdata, ex[7:0]);
            endcase
        end

        // R3 non-byte sizes ignored
        reg_put(8'h00, 2'd1);
        chk8("R3 half-size write ignored", reg_rdata, 8'hFF);
        reg_put(8'h00, 2'd2);
        chk8("R3 word-size write ignored", reg_rdata, 8'hFF);
        reg_put(8'h00, 2'd3);
        chk8("R3 size 3 write ignored", reg_rdata, 8'hFF);
        // R2 reserved bits stay 1
        reg_put(8'h00, 2'd0);
        chk8("R2 reserved bits read 1", reg_rdata, 8'hF0);
        reg_put(8'h0F, 2'd0);

        // R4 same-cycle access sees old enables
        reg_wr = 1'b1; reg_size = 2'd0; reg_wdata = 8'h0E;
        ram_req = 1'b1; ram_we = 1'b0; ram_addr = 6'h01;
        @(negedge clk);
        chk32("R4 access in write cycle uses old enable", ram_rdata, 32'h11111111);
        idle();
        ram_get("R4 next access uses new enable", 6'h01, 32'hDEADBEEF);
        reg_put(8'h0F, 2'd0);

        // R5 page decode from the top address bits
        reg_put(8'h0D, 2'd0);
        ram_get("R5 page 0 stays enabled", 6'h01, 32'h11111111);
        ram_get("R5 page 1 disabled", 6'h12, 32'hDEADBEEF);
        ram_get("R5 page 2 enabled", 6'h25, 32'hAAAA0001);
        reg_put(8'h0F, 2'd0);

        // R11 manual reset
        reg_put(8'h05, 2'd0);
        ram_put(6'h02, 32'hDDDD0002);
        ram_get("R11 read before manual reset", 6'h02, 32'hDDDD0002);
        ram_put(6'h03, 32'hDDDD0003);
        mrst_n = 1'b0;
        @(negedge clk);
        mrst_n = 1'b1;
        @(negedge clk);
        chk8("R11 register kept", reg_rdata, 8'hF5);
        chk32("R11 read data cleared", ram_rdata, 32'h0);
        ram_get("R11 buffer kept", 6'h03, 32'hDDDD0003);
        ram_get("R11 array kept", 6'h02, 32'hDDDD0002);

        // R12 power-on empties buffers, array kept
        ram_put(6'h01, 32'hEEEE0000);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk8("R1 register after second power-on", reg_rdata, 8'hFF);
        ram_get("R12 pending write lost", 6'h01, 32'h11111111);
        ram_get("R12 committed word kept", 6'h25, 32'hAAAA0001);

        summary();
    end
endmodule